// File: doc/BRIEF.md
# Address-Match Breakpoint Unit

This block watches the 16-bit address bus of a small 8-bit controller and compares every cycle's address against a programmable breakpoint address. The breakpoint address is held in two byte registers. When the unit is enabled and the bus address equals the full 16-bit breakpoint, the unit latches a break-pending flag. It drives that flag out as a break interrupt request, which stays high until software acknowledges it. Software may also raise a break on its own by writing a 1 to the pending flag.

Software reaches the unit through a byte-wide register port with a 16-bit register address, a write strobe and write data. Reads are combinational on the same address. The port holds a control/status byte, the two breakpoint bytes and a system-side status byte. The system-side byte keeps a sticky record of breaks taken while the part was in its low-power stop state. While stop is requested and a break is pending, the unit asserts a wake request so the clock controller can resume. The comparator has no dependency on any wait state, so breaks keep working during wait.

Top module: `addr_brk_unit`

## Requirements
- R1: After a synchronous active-low reset, all four registers read 0x00, and `irq_o` and `wake_o` are low.
- R2: The control byte sits at 0xFE0E. Bit 7 is the enable and bit 6 is the pending flag. Bits 5..0 always read 0, and writes to them have no effect. Writing 0 to bit 7 disables the unit and writing 1 enables it.
- R3: The breakpoint high byte sits at 0xFE0C and the low byte at 0xFE0D. Both are fully read/write, and each keeps its value when not written. Reads of any unmapped address return 0x00.
- R4: While enabled, a cycle whose `cpu_addr` equals {high byte, low byte} sets the pending flag at the next clock edge. `irq_o` equals the pending flag.
- R5: While disabled, an equal address does not set the pending flag. The enable used is the value held before the current cycle's register write.
- R6: An address that matches only one of the two bytes does not set the pending flag.
- R7: The pending flag stays set until a control-byte write with bit 6 = 0. If a hardware match happens in the same cycle as that clearing write, the flag stays set.
- R8: A control-byte write with bit 6 = 1 sets the pending flag without any address match, whether or not the unit is enabled.
- R9: The system status byte sits at 0xFE00, and its bit 1 is the stop-break flag. The flag sets at the edge after a cycle in which `stop_in` and the pending flag are both high. It stays set until a write with bit 1 = 0 to 0xFE00; a set condition in that same cycle wins. Writing 1 to bit 1 has no effect, and the other bits read 0.
- R10: `wake_o` is high exactly in cycles where `stop_in` is high and the pending flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | Bus address compared every cycle |
| stop_in | input | 1 | High while the part is in stop state |
| reg_addr | input | 16 | Register port address (read and write) |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| irq_o | output | 1 | Break interrupt request (pending flag) |
| wake_o | output | 1 | Wake request out of stop |

## Verification
A corrupted breakpoint byte or enable bit does not show up right away. It shows when a matching address arrives: `irq_o` stays low, or rises one cycle after a non-matching address. A read of the register shows the bad value in the same cycle. A pending flag that is lost or stuck is visible on `irq_o` in the cycle after the event. It also shows on `wake_o` in the same cycle whenever stop is high. A stop-break flag that fails to set or clear is seen at the next read of 0xFE00, one edge after the cause.

// File: rtl/abu_pkg.sv
// Package: shared constants for the address-match breakpoint unit.
// Assumes an 8-bit register data path; bit positions are fixed by the
// software-visible layout.
package abu_pkg;
    localparam int BYTE_W      = 8;
    localparam int EN_BIT      = 7;
    localparam int PEND_BIT    = 6;
    localparam int STOPF_BIT   = 1;

    // Register write decode, one strobe per action
    typedef struct packed {
        logic ctl_wr;
        logic bph_wr;
        logic bpl_wr;
        logic sys_wr;
    } abu_wsel_t;
endpackage

// File: rtl/abu_regs.sv
// Register block: decodes the byte port, holds enable and breakpoint bytes,
// produces software set/clear strobes for the flags and the read mux.
// Assumes reg_addr is stable during the cycle a read is sampled.
module abu_regs #(
    parameter int          AW        = 16,
    parameter logic [15:0] CTL_ADDR  = 16'hFE0E,
    parameter logic [15:0] BPH_ADDR  = 16'hFE0C,
    parameter logic [15:0] BPL_ADDR  = 16'hFE0D,
    parameter logic [15:0] SYS_ADDR  = 16'hFE00
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [15:0]                reg_addr,
    input  logic                       reg_wr,
    input  logic [abu_pkg::BYTE_W-1:0] reg_wdata,
    input  logic                       pend_q,
    input  logic                       stopf_q,
    output logic [abu_pkg::BYTE_W-1:0] reg_rdata,
    output logic                       en_q,
    output logic [AW-1:0]              bp_addr,
    output logic                       sw_pend_set,
    output logic                       sw_pend_clr,
    output logic                       sw_stop_clr
);
    import abu_pkg::*;
    localparam int HI_W = AW - BYTE_W;

    abu_wsel_t          wsel;
    logic [HI_W-1:0]    bph_q;
    logic [BYTE_W-1:0]  bpl_q;

    // Decode the write address into one strobe per register
    always_comb begin
        wsel.ctl_wr = reg_wr && (reg_addr == CTL_ADDR);
        wsel.bph_wr = reg_wr && (reg_addr == BPH_ADDR);
        wsel.bpl_wr = reg_wr && (reg_addr == BPL_ADDR);
        wsel.sys_wr = reg_wr && (reg_addr == SYS_ADDR);
    end

    // Enable bit and breakpoint bytes, written from the port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            bph_q <= '0;
            bpl_q <= '0;
        end else begin
            if (wsel.ctl_wr) en_q  <= reg_wdata[EN_BIT];
            if (wsel.bph_wr) bph_q <= reg_wdata[HI_W-1:0];
            if (wsel.bpl_wr) bpl_q <= reg_wdata;
        end
    end

    // Software-initiated flag actions
    always_comb begin
        sw_pend_set = wsel.ctl_wr &&  reg_wdata[PEND_BIT];
        sw_pend_clr = wsel.ctl_wr && !reg_wdata[PEND_BIT];
        sw_stop_clr = wsel.sys_wr && !reg_wdata[STOPF_BIT];
    end

    assign bp_addr = {bph_q, bpl_q};

    // Read mux: unimplemented bits and unmapped addresses return zero
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == CTL_ADDR) begin
            reg_rdata[EN_BIT]   = en_q;
            reg_rdata[PEND_BIT] = pend_q;
        end else if (reg_addr == BPH_ADDR) begin
            reg_rdata[HI_W-1:0] = bph_q;
        end else if (reg_addr == BPL_ADDR) begin
            reg_rdata = bpl_q;
        end else if (reg_addr == SYS_ADDR) begin
            reg_rdata[STOPF_BIT] = stopf_q;
        end
    end

    // R3
    bph_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wsel.bph_wr |=> $stable(bph_q));
    // R3
    bpl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wsel.bpl_wr |=> $stable(bpl_q));
endmodule

// File: rtl/abu_match.sv
// Comparator: flags a hit when enabled and the bus address equals the
// breakpoint. Compares byte lanes separately so a one-lane match is visible.
// Assumes both addresses share width AW, a multiple of 8.
module abu_match #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] cpu_addr,
    input  logic [AW-1:0] bp_addr,
    input  logic          en_q,
    output logic          hw_hit
);
    localparam int LANES = AW / 8;

    logic [LANES-1:0] lane_eq;

    // One equality compare per byte lane
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_eq[g] = (cpu_addr[g*8 +: 8] == bp_addr[g*8 +: 8]);
    end

    // Hit only on full-width equality while enabled
    always_comb hw_hit = en_q && (&lane_eq);
endmodule

// File: rtl/abu_flags.sv
// Flag block: holds the break-pending flag and the sticky stop-break flag.
// Hardware set events win over same-cycle software clears.
module abu_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic hw_hit,
    input  logic sw_pend_set,
    input  logic sw_pend_clr,
    input  logic sw_stop_clr,
    input  logic stop_in,
    output logic pend_q,
    output logic stopf_q
);
    logic stop_set;

    always_comb stop_set = stop_in && pend_q;

    // Break-pending flag: set by hit or software, cleared by software
    always_ff @(posedge clk) begin
        if (!rst_n)                       pend_q <= 1'b0;
        else if (hw_hit || sw_pend_set)   pend_q <= 1'b1;
        else if (sw_pend_clr)             pend_q <= 1'b0;
    end

    // Stop-break flag: records a pending break seen during stop
    always_ff @(posedge clk) begin
        if (!rst_n)           stopf_q <= 1'b0;
        else if (stop_set)    stopf_q <= 1'b1;
        else if (sw_stop_clr) stopf_q <= 1'b0;
    end

    // R4
    hit_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hw_hit |=> pend_q);
    // R7
    pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !sw_pend_clr) |=> pend_q);
    // R9
    stop_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_in && pend_q) |=> stopf_q);
    // R9
    stopf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stopf_q && !sw_stop_clr) |=> stopf_q);
endmodule

// File: rtl/addr_brk_unit.sv
// Top: address-match breakpoint unit. Connects register port, comparator
// and flag logic; drives interrupt and stop-wake requests.
// Assumes one bus address per clock and a synchronous active-low reset.
module addr_brk_unit #(
    parameter int          AW        = 16,
    parameter logic [15:0] CTL_ADDR  = 16'hFE0E,
    parameter logic [15:0] BPH_ADDR  = 16'hFE0C,
    parameter logic [15:0] BPL_ADDR  = 16'hFE0D,
    parameter logic [15:0] SYS_ADDR  = 16'hFE00
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] cpu_addr,
    input  logic          stop_in,
    input  logic [15:0]   reg_addr,
    input  logic          reg_wr,
    input  logic [7:0]    reg_wdata,
    output logic [7:0]    reg_rdata,
    output logic          irq_o,
    output logic          wake_o
);
    logic          en_q, pend_q, stopf_q, hw_hit;
    logic          sw_pend_set, sw_pend_clr, sw_stop_clr;
    logic [AW-1:0] bp_addr;

    abu_regs #(
        .AW(AW), .CTL_ADDR(CTL_ADDR), .BPH_ADDR(BPH_ADDR),
        .BPL_ADDR(BPL_ADDR), .SYS_ADDR(SYS_ADDR)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .pend_q(pend_q), .stopf_q(stopf_q),
        .reg_rdata(reg_rdata), .en_q(en_q), .bp_addr(bp_addr),
        .sw_pend_set(sw_pend_set), .sw_pend_clr(sw_pend_clr),
        .sw_stop_clr(sw_stop_clr)
    );

    abu_match #(.AW(AW)) u_match (
        .cpu_addr(cpu_addr), .bp_addr(bp_addr), .en_q(en_q), .hw_hit(hw_hit)
    );

    abu_flags u_flags (
        .clk(clk), .rst_n(rst_n), .hw_hit(hw_hit), .sw_pend_set(sw_pend_set),
        .sw_pend_clr(sw_pend_clr), .sw_stop_clr(sw_stop_clr),
        .stop_in(stop_in), .pend_q(pend_q), .stopf_q(stopf_q)
    );

    // Request outputs
    assign irq_o  = pend_q;
    assign wake_o = stop_in && pend_q;

    // R5
    no_hit_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !pend_q && !sw_pend_set) |=> !irq_o);
endmodule

// File: tb/sim_addr_brk_unit.sv
module sim_addr_brk_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        stop_in = 1'b0;
    logic [15:0] reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        irq_o, wake_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // model state
    bit       m_en, m_pend, m_stopf;
    bit [7:0] m_bph, m_bpl;

    always #4 clk = ~clk;

    addr_brk_unit u0 (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .stop_in(stop_in),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_o(irq_o), .wake_o(wake_o)
    );

    function automatic bit [7:0] exp_rd(input bit [15:0] a);
        case (a)
            16'hFE0E: exp_rd = {m_en, m_pend, 6'b0};
            16'hFE0C: exp_rd = m_bph;
            16'hFE0D: exp_rd = m_bpl;
            16'hFE00: exp_rd = {6'b0, m_stopf, 1'b0};
            default:  exp_rd = 8'h00;
        endcase
    endfunction

    task automatic chk(input string tag, input int got, input int exp);
        n_run++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    // One cycle: drive at negedge, check combinational outputs, advance model
    task automatic step(input bit [15:0] ca, input bit st, input bit wr,
                        input bit [15:0] ra, input bit [7:0] wd, input string tag);
        bit hit, ctl_w, sys_w;
        @(negedge clk);
        cpu_addr = ca; stop_in = st; reg_wr = wr; reg_addr = ra; reg_wdata = wd;
        #1;
        chk(tag, reg_rdata, exp_rd(ra));
        chk(tag, irq_o, m_pend);
        chk("R10", wake_o, st && m_pend);
        hit   = m_en && (ca == {m_bph, m_bpl});
        ctl_w = wr && ra == 16'hFE0E;
        sys_w = wr && ra == 16'hFE00;
        // stop flag uses current pend
        if (st && m_pend) m_stopf = 1'b1;
        else if (sys_w && !wd[1]) m_stopf = 1'b0;
        if (hit || (ctl_w && wd[6])) m_pend = 1'b1;
        else if (ctl_w && !wd[6]) m_pend = 1'b0;
        if (ctl_w) m_en = wd[7];
        if (wr && ra == 16'hFE0C) m_bph = wd;
        if (wr && ra == 16'hFE0D) m_bpl = wd;
    endtask

    task automatic rd(input bit [15:0] ra, input string tag);
        step(16'h0000, 1'b0, 1'b0, ra, 8'h00, tag);
    endtask

    task automatic wr(input bit [15:0] ra, input bit [7:0] wd, input string tag);
        step(16'h0000, 1'b0, 1'b1, ra, wd, tag);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fail++; n_run++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        // R1: reset state
        @(negedge clk);
        rst_n = 1'b1;
        rd(16'hFE0E, "R1"); rd(16'hFE0C, "R1"); rd(16'hFE0D, "R1"); rd(16'hFE00, "R1");
        // R3: breakpoint bytes and unmapped read
        wr(16'hFE0C, 8'h12, "R3"); wr(16'hFE0D, 8'h34, "R3");
        rd(16'hFE0C, "R3"); rd(16'hFE0D, "R3"); rd(16'h1234, "R3");
        // R5: disabled, matching address ignored
        step(16'h1234, 1'b0, 1'b0, 16'hFE0E, 8'h00, "R5");
        rd(16'hFE0E, "R5");
        // R2: enable, unimplemented bits ignored
        wr(16'hFE0E, 8'hBF, "R2");
        rd(16'hFE0E, "R2");
        // R6: one-byte matches
        step(16'h1200, 1'b0, 1'b0, 16'hFE0E, 8'h00, "R6");
        step(16'h0034, 1'b0, 1'b0, 16'hFE0E, 8'h00, "R6");
        rd(16'hFE0E, "R6");
        // R4: full match
        step(16'h1234, 1'b0, 1'b0, 16'hFE0E, 8'h00, "R4");
        rd(16'hFE0E, "R4");
        // R7: sticky, then clear-vs-match in same cycle, then clear
        rd(16'hFE0E, "R7");
        step(16'h1234, 1'b0, 1'b1, 16'hFE0E, 8'h80, "R7");
        rd(16'hFE0E, "R7");
        wr(16'hFE0E, 8'h80, "R7");
        rd(16'hFE0E, "R7");
        // R2: disable via bit 7, then R5 same-cycle enable uses old value
        wr(16'hFE0E, 8'h00, "R2");
        step(16'h1234, 1'b0, 1'b1, 16'hFE0E, 8'h80, "R5");
        rd(16'hFE0E, "R5");
        wr(16'hFE0E, 8'h00, "R2");
        // R8: software forced break while disabled
        wr(16'hFE0E, 8'h40, "R8");
        rd(16'hFE0E, "R8");
        // R9/R10: stop with pending
        step(16'h0000, 1'b1, 1'b0, 16'hFE00, 8'h00, "R9");
        rd(16'hFE00, "R9");
        wr(16'hFE00, 8'hFF, "R9");
        rd(16'hFE00, "R9");
        wr(16'hFE0E, 8'h00, "R7");
        step(16'h0000, 1'b1, 1'b0, 16'hFE00, 8'h00, "R10");
        wr(16'hFE00, 8'h00, "R9");
        rd(16'hFE00, "R9");
        // random mix
        for (int i = 0; i < 3000; i++) begin
            bit [15:0] ra, ca;
            bit [7:0]  wd;
            bit        w;
            case ($urandom % 5)
                0: ra = 16'hFE0E; 1: ra = 16'hFE0C; 2: ra = 16'hFE0D;
                3: ra = 16'hFE00; default: ra = 16'($urandom);
            endcase
            ca = ($urandom % 3 == 0) ? {m_bph, m_bpl} ^ 16'($urandom % 2 ? 0 : (1 << ($urandom % 16)))
                                     : 16'($urandom);
            w  = ($urandom % 4 == 0);
            wd = 8'($urandom);
            step(ca, 1'($urandom % 2), w, ra, wd, "R4");
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule